// File: doc/BRIEF.md
# Main Supply Sleep and Isolation Sequencer

This block sits in the always-on clock domain and takes the main core supply into deep sleep and back out. A sleep request starts the entry sequence. The block first asks the flash to prepare for power loss and waits for the flash to acknowledge. It then raises an early isolation warning, then the isolation enable, and only then drives the active-low power enable low. After that it waits for the main power-good input to fall.

A wake request in the sleep state reverses the order. Power is enabled first. The block then waits for power-good and for the reset-done input from the powered-off modules. It drops isolation, and drops the early warning one cycle later. One cycle at the 200 kHz clock is 5 µs, which covers the 30 ns margins the early warning needs on each side of the isolation enable.

Both supply waits are limited by a programmable cycle timeout. If the timeout expires, the block raises a sticky error and freezes all outputs in the state it was in. The states are ACTIVE, FLASH_PD, EARLY_ISO, ISO, PWR_OFF, SLEEP, PWR_ON, WAIT_RST, ISO_RELEASE and EARLY_ISO_RELEASE. The transitions are:

- ACTIVE to FLASH_PD on a sleep request.
- FLASH_PD to EARLY_ISO on the flash acknowledge.
- EARLY_ISO to ISO, and ISO to PWR_OFF, unconditionally.
- PWR_OFF to SLEEP when power-good falls.
- SLEEP to PWR_ON on a wake request, or on a wake request that was held.
- PWR_ON to WAIT_RST when power-good rises.
- WAIT_RST to ISO_RELEASE when reset-done is high.
- ISO_RELEASE to EARLY_ISO_RELEASE, and EARLY_ISO_RELEASE to ACTIVE, unconditionally.

Top module: `pwr_iso_seq`

## Requirements
- R1: After reset the outputs are: flash power-down request 0, early isolation 0, isolation 0, power enable 1, error 0.
- R2: A sleep request in ACTIVE raises the flash power-down request on the next clock edge. Isolation outputs stay low until the flash acknowledge is seen.
- R3: Early isolation rises on the edge after the acknowledge is sampled. Isolation rises exactly one edge later, so early isolation always leads isolation.
- R4: The power enable falls one edge after isolation rises. While the power enable is 0, isolation and the flash request are both 1.
- R5: After the power enable falls, the block stays in PWR_OFF until power-good is sampled low, then enters SLEEP. In SLEEP the outputs are flash request 1, early isolation 1, isolation 1, power enable 0.
- R6: A wake request sampled in FLASH_PD, EARLY_ISO, ISO or PWR_OFF is held. The block leaves SLEEP on the first edge in SLEEP without a new request.
- R7: A wake request in SLEEP raises the power enable on the next edge. Isolation stays 1 until power-good has been sampled high and, after that, reset-done has been sampled high.
- R8: Isolation falls on the edge after reset-done is sampled high in WAIT_RST. Early isolation falls one edge after isolation, and the block is back in ACTIVE one edge later.
- R9: If the supply wait in PWR_OFF or PWR_ON lasts TIMEOUT+1 edges without confirmation, the error output rises. The error is sticky, and every other output then stays frozen whatever the inputs do.
- R10: A wake request in ACTIVE is neither acted on nor held. A sleep request outside ACTIVE has no effect.
- R11: The flash power-down request falls on the same edge the power enable rises on wake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock (200 kHz) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Request to power down the main supply |
| wake_req_i | input | 1 | Request to power the main supply back up |
| flash_pd_ack_i | input | 1 | Flash reports it is ready for power loss |
| pwr_good_i | input | 1 | Main supply is present |
| rst_done_i | input | 1 | Powered-off modules have finished reset |
| timeout_cfg_i | input | TO_W | Supply-wait timeout limit in cycles |
| flash_pd_req_o | output | 1 | Ask the flash to prepare for power loss |
| early_iso_o | output | 1 | Early warning that brackets isolation |
| iso_en_o | output | 1 | Isolation enable for main-domain signals |
| main_pwr_en_o | output | 1 | Main power enable, active low (0 = off) |
| err_o | output | 1 | Sticky supply-wait timeout error |

## Verification
The bench targets the edge ordering: early isolation before isolation before power-off, and the reverse on release. A design that swapped two states would let isolation and power move on the same edge, or drop early isolation with isolation. It holds power-good high in PWR_OFF and keeps reset-done low after power returns, so a sequencer that did not wait would reach SLEEP or drop isolation too soon. It sends a wake request during entry and another in ACTIVE; a design that lost the first would hang in SLEEP, and one that latched the second would wake spuriously later. Finally it starves both supply waits, so a timer that was off by one would raise the error on the wrong edge, and one that did not freeze the outputs would let them move after the error.

// File: rtl/pwr_iso_seq_pkg.sv
package pwr_iso_seq_pkg;

    typedef enum logic [3:0] {
        ST_ACTIVE            = 4'd0,
        ST_FLASH_PD          = 4'd1,
        ST_EARLY_ISO         = 4'd2,
        ST_ISO               = 4'd3,
        ST_PWR_OFF           = 4'd4,
        ST_SLEEP             = 4'd5,
        ST_PWR_ON            = 4'd6,
        ST_WAIT_RST          = 4'd7,
        ST_ISO_RELEASE       = 4'd8,
        ST_EARLY_ISO_RELEASE = 4'd9
    } seq_state_e;

    typedef struct packed {
        logic flash_req;
        logic early_iso;
        logic iso_en;
        logic pwr_en;
    } seq_out_t;

    localparam seq_out_t SEQ_OUT_RESET = '{flash_req: 1'b0, early_iso: 1'b0,
                                           iso_en: 1'b0, pwr_en: 1'b1};

endpackage

// File: rtl/pwr_iso_seq_timer.sv
module pwr_iso_seq_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            waiting_i,
    input  logic            confirmed_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            expired_o
);

    logic [TO_W-1:0] cnt_q;
    logic            err_q;
    logic            hit;

    assign hit = waiting_i && !confirmed_i && (cnt_q == limit_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (hit) begin
                err_q <= 1'b1;
            end
            if (!waiting_i || confirmed_i) begin
                cnt_q <= '0;
            end else if (!hit && !err_q) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expired_o = err_q;

    AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_q |=> err_q) else $error("timeout error cleared");  // R9

    AST_ERR_ONLY_WHILE_WAITING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(err_q) |-> $past(waiting_i)) else $error("error outside wait");  // R9

endmodule

// File: rtl/pwr_iso_seq_wake_hold.sv
module pwr_iso_seq_wake_hold (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic capture_i,
    input  logic consume_i,
    input  logic wake_req_i,
    output logic pend_o
);

    logic pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= 1'b0;
        end else if (consume_i) begin
            pend_q <= 1'b0;
        end else if (capture_i && wake_req_i) begin
            pend_q <= 1'b1;
        end
    end

    assign pend_o = pend_q;

    AST_PEND_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        consume_i |=> !pend_q) else $error("held wake not consumed");  // R6

endmodule

// File: rtl/pwr_iso_seq_outdec.sv
module pwr_iso_seq_outdec
    import pwr_iso_seq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  seq_state_e next_i,
    output seq_out_t   out_o
);

    seq_out_t dec;
    seq_out_t out_q;

    always_comb begin
        dec = SEQ_OUT_RESET;
        unique case (next_i)
            ST_ACTIVE:            dec = '{1'b0, 1'b0, 1'b0, 1'b1};
            ST_FLASH_PD:          dec = '{1'b1, 1'b0, 1'b0, 1'b1};
            ST_EARLY_ISO:         dec = '{1'b1, 1'b1, 1'b0, 1'b1};
            ST_ISO:               dec = '{1'b1, 1'b1, 1'b1, 1'b1};
            ST_PWR_OFF:           dec = '{1'b1, 1'b1, 1'b1, 1'b0};
            ST_SLEEP:             dec = '{1'b1, 1'b1, 1'b1, 1'b0};
            ST_PWR_ON:            dec = '{1'b0, 1'b1, 1'b1, 1'b1};
            ST_WAIT_RST:          dec = '{1'b0, 1'b1, 1'b1, 1'b1};
            ST_ISO_RELEASE:       dec = '{1'b0, 1'b1, 1'b0, 1'b1};
            ST_EARLY_ISO_RELEASE: dec = '{1'b0, 1'b0, 1'b0, 1'b1};
            default:              dec = SEQ_OUT_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q <= SEQ_OUT_RESET;
        end else begin
            out_q <= dec;
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/pwr_iso_seq.sv
module pwr_iso_seq
    import pwr_iso_seq_pkg::*;
#(
    parameter int TO_W = 16
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sleep_req_i,
    input  logic            wake_req_i,
    input  logic            flash_pd_ack_i,
    input  logic            pwr_good_i,
    input  logic            rst_done_i,
    input  logic [TO_W-1:0] timeout_cfg_i,
    output logic            flash_pd_req_o,
    output logic            early_iso_o,
    output logic            iso_en_o,
    output logic            main_pwr_en_o,
    output logic            err_o
);

    seq_state_e state_q, state_d;
    seq_out_t   outs;
    logic       in_entry, supply_wait, supply_ok, expired, wake_pend, leave_sleep;

    assign in_entry    = (state_q == ST_FLASH_PD) || (state_q == ST_EARLY_ISO) ||
                         (state_q == ST_ISO)      || (state_q == ST_PWR_OFF);
    assign supply_wait = (state_q == ST_PWR_OFF) || (state_q == ST_PWR_ON);
    assign supply_ok   = (state_q == ST_PWR_OFF) ? !pwr_good_i : pwr_good_i;
    assign leave_sleep = (state_q == ST_SLEEP) && (wake_req_i || wake_pend);

    pwr_iso_seq_timer #(.TO_W(TO_W)) u_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .waiting_i   (supply_wait),
        .confirmed_i (supply_ok),
        .limit_i     (timeout_cfg_i),
        .expired_o   (expired)
    );

    pwr_iso_seq_wake_hold u_wake (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_i  (in_entry),
        .consume_i  (leave_sleep),
        .wake_req_i (wake_req_i),
        .pend_o     (wake_pend)
    );

    always_comb begin
        state_d = state_q;
        if (!expired) begin
            unique case (state_q)
                ST_ACTIVE:            if (sleep_req_i)    state_d = ST_FLASH_PD;
                ST_FLASH_PD:          if (flash_pd_ack_i) state_d = ST_EARLY_ISO;
                ST_EARLY_ISO:         state_d = ST_ISO;
                ST_ISO:               state_d = ST_PWR_OFF;
                ST_PWR_OFF:           if (!pwr_good_i)    state_d = ST_SLEEP;
                ST_SLEEP:             if (leave_sleep)    state_d = ST_PWR_ON;
                ST_PWR_ON:            if (pwr_good_i)     state_d = ST_WAIT_RST;
                ST_WAIT_RST:          if (rst_done_i)     state_d = ST_ISO_RELEASE;
                ST_ISO_RELEASE:       state_d = ST_EARLY_ISO_RELEASE;
                ST_EARLY_ISO_RELEASE: state_d = ST_ACTIVE;
                default:              state_d = ST_ACTIVE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    pwr_iso_seq_outdec u_outdec (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .next_i (state_d),
        .out_o  (outs)
    );

    assign flash_pd_req_o = outs.flash_req;
    assign early_iso_o    = outs.early_iso;
    assign iso_en_o       = outs.iso_en;
    assign main_pwr_en_o  = outs.pwr_en;
    assign err_o          = expired;

    AST_EARLY_LEADS_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(iso_en_o) |-> $past(early_iso_o)) else $error("iso rose without early");  // R3

    AST_ISO_BEFORE_PWR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(main_pwr_en_o) |-> $past(iso_en_o)) else $error("power cut without iso");  // R4

    AST_FLASH_READY_WHILE_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !main_pwr_en_o |-> (flash_pd_req_o && iso_en_o)) else $error("power off unsafe");  // R4

    AST_EARLY_TRAILS_ISO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(iso_en_o) |-> early_iso_o) else $error("early dropped with iso");  // R8

    AST_ISO_WAITS_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(iso_en_o) |-> $past(rst_done_i)) else $error("iso released before reset");  // R7

    AST_EARLY_FALL_SAFE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(early_iso_o) |-> !iso_en_o) else $error("early fell while isolated");  // R8

    AST_FROZEN_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> $stable(iso_en_o) && $stable(main_pwr_en_o) && $stable(early_iso_o))
        else $error("outputs moved after error");  // R9

endmodule

// File: tb/pwr_iso_seq_tb_top.sv
module pwr_iso_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TO_W       = 16;
    localparam int NVEC       = 26;

    // {sleep,wake,ack,pg,rd , flash,early,iso,pwr,err , req}
    localparam logic [13:0] VEC [NVEC] = '{
        14'b10011_10010_0010, // 0  R2 sleep -> FLASH_PD
        14'b00011_10010_0010, // 1  R2 no ack, no isolation
        14'b00111_11010_0011, // 2  R3 early first
        14'b01111_11110_0110, // 3  R6 wake during entry, iso rises
        14'b00111_11100_0100, // 4  R4 power off after iso
        14'b00110_11100_0101, // 5  R5 pg still high, wait
        14'b00100_11100_0101, // 6  R5 pg low -> SLEEP
        14'b00000_01110_0110, // 7  R6 held wake -> PWR_ON
        14'b00000_01110_0111, // 8  R7 pg low, iso held
        14'b00010_01110_0111, // 9  R7 pg high -> WAIT_RST
        14'b00010_01110_0111, // 10 R7 reset not done
        14'b00011_01010_1000, // 11 R8 iso falls
        14'b00011_00010_1000, // 12 R8 early falls
        14'b00011_00010_1000, // 13 R8 ACTIVE
        14'b01011_00010_1010, // 14 R10 wake in ACTIVE ignored
        14'b10011_10010_0010, // 15 R2 second entry
        14'b10111_11010_1010, // 16 R10 sleep during sequence ignored
        14'b00111_11110_0011, // 17 R3
        14'b00100_11100_0100, // 18 R4
        14'b00100_11100_0101, // 19 R5
        14'b00100_11100_1010, // 20 R10 no stale wake
        14'b01100_01110_1011, // 21 R11 flash req drops on wake
        14'b00011_01110_0111, // 22 R7
        14'b00011_01010_1000, // 23 R8
        14'b00011_00010_1000, // 24 R8
        14'b00011_00010_1000  // 25 R8
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0, wake_req = 1'b0, ack = 1'b0;
    logic            pg = 1'b1, rd = 1'b1;
    logic [TO_W-1:0] to_cfg = 16'd3;
    logic            f_req, early, iso, pwr_en, err;
    int              n_tests = 0, n_fail = 0;
    bit              finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_iso_seq #(.TO_W(TO_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .sleep_req_i    (sleep_req),
        .wake_req_i     (wake_req),
        .flash_pd_ack_i (ack),
        .pwr_good_i     (pg),
        .rst_done_i     (rd),
        .timeout_cfg_i  (to_cfg),
        .flash_pd_req_o (f_req),
        .early_iso_o    (early),
        .iso_en_o       (iso),
        .main_pwr_en_o  (pwr_en),
        .err_o          (err)
    );

    task automatic check(input string tag, input logic [4:0] exp);
        logic [4:0] got;
        got = {f_req, early, iso, pwr_en, err};
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (flash,early,iso,pwr,err)", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [4:0] v);
        {sleep_req, wake_req, ack, pg, rd} = v;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive(5'b00011);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R1 reset state", 5'b00010);

        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k][13:9]);
            step();
            check($sformatf("R%0d vector %0d", VEC[k][3:0], k), VEC[k][8:4]);
        end

        // R9 timeout while waiting for the supply to drop
        do_reset();
        drive(5'b10011); step();
        drive(5'b00111); step(); step(); step();   // PWR_OFF entered
        step(); step(); step();
        check("R9 no error before limit (off)", 5'b11100);
        step();
        check("R9 error at limit (off)", 5'b11101);
        drive(5'b01100); step(); step();
        check("R9 frozen after error (off)", 5'b11101);

        // R9 timeout while waiting for the supply to return
        do_reset();
        drive(5'b10011); step();
        drive(5'b00111); step(); step(); step();
        drive(5'b00100); step();                   // SLEEP
        drive(5'b01000); step();                   // PWR_ON entered
        drive(5'b00000);
        step(); step(); step();
        check("R9 no error before limit (on)", 5'b01110);
        step();
        check("R9 error at limit (on)", 5'b01111);
        drive(5'b00011); step(); step();
        check("R9 frozen after error (on)", 5'b01111);

        // R1 reset clears error
        do_reset();
        check("R1 reset after error", 5'b00010);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule